// File: doc/BRIEF.md
# Snoop-Hit Line Buffer

This block sits between the system bus and the memory controller and keeps a copy of one cache line. When a cache that owns a line in the Modified state is snooped, it pushes the dirty line out as a write-back. The requester then retries its read of that same address. The block forwards every write beat to memory, so memory is always current. It also records the line of a snoop write-back, together with its line address. The retried read can then be answered straight from that copy, without the memory's first-word delay.

A line is a burst of `BEATS` beats of `DATA_W` bits each, with the beats sent in ascending order. With the defaults this is four 64-bit beats, or 32 bytes. Bus writes carry a flag that marks a snoop write-back. A plain write clears the recorded copy when it targets the same line. A read that does not match the copy goes to memory as a single line request, and the memory's beats are passed back unchanged. The memory returns its first beat `MEM_FIRST`-class latency after it accepts a request, and one beat per cycle after that. The bench models that memory with 6 cycles to the first word.

Top module: `snoop_hit_buffer`

## Requirements
- R1: After reset the copy is empty, `br_data_valid`, `mr_req_valid` and `mw_valid` are low, and `br_req_ready` is high. A line recorded before a reset is not served afterwards.
- R2: Each accepted bus write beat appears on the memory write port with the same data. Its word address is `{bw_line, beat}`, with beat 0 to BEATS-1 in order. While `mw_ready` is low, `bw_ready` is low.
- R3: A burst written with `bw_snoop` = 1 is recorded together with its line address. The copy becomes valid only after the last beat. The first beat of a new snoop write-back discards the previous copy.
- R4: A read that hits the valid copy returns all BEATS beats from the copy, in ascending order, on consecutive cycles. The first beat is valid in the cycle after the read is accepted.
- R5: A read that misses issues exactly one line request on `mr_req_*` in the cycle after acceptance and passes the memory's beats to the bus. With a memory that needs 6 cycles to the first word, the first beat comes 7 cycles after acceptance.
- R6: A plain write (`bw_snoop` = 0) to the recorded line invalidates the copy. A plain write to any other line leaves the copy valid.
- R7: A read is accepted only when no read is in flight and no write beat is offered or partly transferred. When a write and a read are offered in the same cycle, the write goes first. Writes are held off while a read is in flight.
- R8: Serving a hit does not consume the copy. A repeated read of the same line hits again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bw_valid | input | 1 | Bus write beat offered |
| bw_ready | output | 1 | Bus write beat accepted |
| bw_snoop | input | 1 | Burst is a snoop write-back |
| bw_line | input | LINE_AW | Line address of the write burst |
| bw_data | input | DATA_W | Write beat data |
| br_req_valid | input | 1 | Bus line read request offered |
| br_req_ready | output | 1 | Read request accepted |
| br_line | input | LINE_AW | Line address of the read |
| br_data_valid | output | 1 | Read beat valid |
| br_data | output | DATA_W | Read beat data |
| mw_valid | output | 1 | Memory write beat valid |
| mw_ready | input | 1 | Memory accepts write beat |
| mw_addr | output | LINE_AW+log2(BEATS) | Memory word address |
| mw_data | output | DATA_W | Memory write data |
| mr_req_valid | output | 1 | Memory line read request |
| mr_req_ready | input | 1 | Memory accepts read request |
| mr_addr | output | LINE_AW | Memory read line address |
| mr_data_valid | input | 1 | Memory read beat valid |
| mr_data | input | DATA_W | Memory read beat data |

## Verification
A plain write that invalidates the recorded line and a read of that same line can be offered in the same cycle. The bench provokes this by first recording a line with a snoop write-back. It then raises a plain write burst to that line and a read of it on the same clock edge. The bench checks that the read is held off while the write is offered. It then checks that the read comes back with memory latency, carrying the newly written data rather than the stale copy.

// File: rtl/shb_pkg.sv
package shb_pkg;
   typedef enum logic [1:0] {
      RD_IDLE  = 2'd0,
      RD_HIT   = 2'd1,
      RD_MREQ  = 2'd2,
      RD_MDATA = 2'd3
   } rd_state_e;
endpackage

// File: rtl/shb_wr_path.sv
module shb_wr_path #(
   parameter int LINE_AW = 26,
   parameter int DATA_W  = 64,
   parameter int BEATS   = 4,
   localparam int BEAT_W = $clog2(BEATS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bw_valid,
   input  logic                      bw_snoop,
   input  logic [LINE_AW-1:0]        bw_line,
   input  logic [DATA_W-1:0]         bw_data,
   input  logic                      rd_idle,
   input  logic                      mw_ready,
   output logic                      bw_ready,
   output logic                      mw_valid,
   output logic [LINE_AW+BEAT_W-1:0] mw_addr,
   output logic [DATA_W-1:0]         mw_data,
   output logic [BEAT_W-1:0]         beat,
   output logic                      cap_we,
   output logic                      cap_first,
   output logic                      cap_last,
   output logic                      plain_wr,
   output logic                      wr_busy
);
   logic              acc;
   logic              last_beat;
   logic [BEAT_W-1:0] cnt_q;

   assign bw_ready  = mw_ready && rd_idle;
   assign mw_valid  = bw_valid && rd_idle;
   assign mw_addr   = {bw_line, cnt_q};
   assign mw_data   = bw_data;
   assign acc       = bw_valid && bw_ready;
   assign last_beat = (cnt_q == BEAT_W'(BEATS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (acc)    cnt_q <= last_beat ? '0 : cnt_q + 1'b1;
   end

   assign beat      = cnt_q;
   assign cap_we    = acc && bw_snoop;
   assign cap_first = cap_we && (cnt_q == '0);
   assign cap_last  = cap_we && last_beat;
   assign plain_wr  = acc && !bw_snoop;
   assign wr_busy   = (cnt_q != '0);
endmodule

// File: rtl/shb_line_store.sv
module shb_line_store #(
   parameter int LINE_AW = 26,
   parameter int DATA_W  = 64,
   parameter int BEATS   = 4,
   localparam int BEAT_W = $clog2(BEATS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_we,
   input  logic               cap_first,
   input  logic               cap_last,
   input  logic [BEAT_W-1:0]  cap_beat,
   input  logic [LINE_AW-1:0] cap_line,
   input  logic [DATA_W-1:0]  cap_data,
   input  logic               plain_wr,
   input  logic [BEAT_W-1:0]  rd_beat,
   output logic               hold_valid,
   output logic [LINE_AW-1:0] hold_line,
   output logic [DATA_W-1:0]  rd_data
);
   logic [BEATS-1:0][DATA_W-1:0] line_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_valid <= 1'b0;
         hold_line  <= '0;
      end else begin
         if (cap_first) begin
            hold_valid <= 1'b0;
            hold_line  <= cap_line;
         end else if (cap_last) begin
            hold_valid <= 1'b1;
         end else if (plain_wr && cap_line == hold_line) begin
            hold_valid <= 1'b0;
         end
      end
   end

   for (genvar i = 0; i < BEATS; i++) begin : g_beat
      logic [DATA_W-1:0] beat_q;
      always_ff @(posedge clk) begin
         if (cap_we && cap_beat == BEAT_W'(i)) beat_q <= cap_data;
      end
      assign line_w[i] = beat_q;
   end

   assign rd_data = line_w[rd_beat];
endmodule

// File: rtl/shb_rd_engine.sv
module shb_rd_engine
   import shb_pkg::*;
#(
   parameter int LINE_AW = 26,
   parameter int DATA_W  = 64,
   parameter int BEATS   = 4,
   localparam int BEAT_W = $clog2(BEATS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               br_req_valid,
   input  logic [LINE_AW-1:0] br_line,
   input  logic               wr_quiet,
   input  logic               hold_valid,
   input  logic [LINE_AW-1:0] hold_line,
   input  logic [DATA_W-1:0]  buf_data,
   input  logic               mr_req_ready,
   input  logic               mr_data_valid,
   input  logic [DATA_W-1:0]  mr_data,
   output logic               br_req_ready,
   output logic               br_data_valid,
   output logic [DATA_W-1:0]  br_data,
   output logic               mr_req_valid,
   output logic [LINE_AW-1:0] mr_addr,
   output logic [BEAT_W-1:0]  rd_beat,
   output logic               rd_idle
);
   rd_state_e         state_q;
   logic [BEAT_W-1:0] cnt_q;
   logic              acc;
   logic              hit;
   logic              last_beat;

   assign rd_idle      = (state_q == RD_IDLE);
   assign br_req_ready = rd_idle && wr_quiet;
   assign acc          = br_req_valid && br_req_ready;
   assign hit          = hold_valid && (br_line == hold_line);
   assign last_beat    = (cnt_q == BEAT_W'(BEATS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RD_IDLE;
         cnt_q   <= '0;
         mr_addr <= '0;
      end else begin
         unique case (state_q)
            RD_IDLE: if (acc) begin
               cnt_q   <= '0;
               mr_addr <= br_line;
               state_q <= hit ? RD_HIT : RD_MREQ;
            end
            RD_HIT: begin
               cnt_q <= cnt_q + 1'b1;
               if (last_beat) state_q <= RD_IDLE;
            end
            RD_MREQ: if (mr_req_ready) state_q <= RD_MDATA;
            RD_MDATA: if (mr_data_valid) begin
               cnt_q <= cnt_q + 1'b1;
               if (last_beat) state_q <= RD_IDLE;
            end
            default: state_q <= RD_IDLE;
         endcase
      end
   end

   assign rd_beat       = cnt_q;
   assign mr_req_valid  = (state_q == RD_MREQ);
   assign br_data_valid = (state_q == RD_HIT) || (state_q == RD_MDATA && mr_data_valid);
   assign br_data       = (state_q == RD_HIT) ? buf_data : mr_data;
endmodule

// File: rtl/snoop_hit_buffer.sv
module snoop_hit_buffer #(
   parameter int LINE_AW = 26,
   parameter int DATA_W  = 64,
   parameter int BEATS   = 4,
   localparam int BEAT_W = $clog2(BEATS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bw_valid,
   output logic                      bw_ready,
   input  logic                      bw_snoop,
   input  logic [LINE_AW-1:0]        bw_line,
   input  logic [DATA_W-1:0]         bw_data,
   input  logic                      br_req_valid,
   output logic                      br_req_ready,
   input  logic [LINE_AW-1:0]        br_line,
   output logic                      br_data_valid,
   output logic [DATA_W-1:0]         br_data,
   output logic                      mw_valid,
   input  logic                      mw_ready,
   output logic [LINE_AW+BEAT_W-1:0] mw_addr,
   output logic [DATA_W-1:0]         mw_data,
   output logic                      mr_req_valid,
   input  logic                      mr_req_ready,
   output logic [LINE_AW-1:0]        mr_addr,
   input  logic                      mr_data_valid,
   input  logic [DATA_W-1:0]         mr_data
);
   if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
      $error("snoop_hit_buffer: BEATS must be a power of two, at least 2");
   end
   if (LINE_AW < 1 || DATA_W < 8) begin : g_bad_width
      $error("snoop_hit_buffer: LINE_AW >= 1 and DATA_W >= 8 required");
   end

   logic [BEAT_W-1:0]  wr_beat;
   logic [BEAT_W-1:0]  rd_beat;
   logic               cap_we, cap_first, cap_last, plain_wr, wr_busy;
   logic               rd_idle;
   logic               hold_valid;
   logic [LINE_AW-1:0] hold_line;
   logic [DATA_W-1:0]  buf_data;

   shb_wr_path #(.LINE_AW(LINE_AW), .DATA_W(DATA_W), .BEATS(BEATS)) u_wr (
      .clk(clk), .rst_n(rst_n), .bw_valid(bw_valid), .bw_snoop(bw_snoop),
      .bw_line(bw_line), .bw_data(bw_data), .rd_idle(rd_idle), .mw_ready(mw_ready),
      .bw_ready(bw_ready), .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data),
      .beat(wr_beat), .cap_we(cap_we), .cap_first(cap_first), .cap_last(cap_last),
      .plain_wr(plain_wr), .wr_busy(wr_busy)
   );

   shb_line_store #(.LINE_AW(LINE_AW), .DATA_W(DATA_W), .BEATS(BEATS)) u_store (
      .clk(clk), .rst_n(rst_n), .cap_we(cap_we), .cap_first(cap_first),
      .cap_last(cap_last), .cap_beat(wr_beat), .cap_line(bw_line), .cap_data(bw_data),
      .plain_wr(plain_wr), .rd_beat(rd_beat), .hold_valid(hold_valid),
      .hold_line(hold_line), .rd_data(buf_data)
   );

   shb_rd_engine #(.LINE_AW(LINE_AW), .DATA_W(DATA_W), .BEATS(BEATS)) u_rd (
      .clk(clk), .rst_n(rst_n), .br_req_valid(br_req_valid), .br_line(br_line),
      .wr_quiet(!bw_valid && !wr_busy), .hold_valid(hold_valid), .hold_line(hold_line),
      .buf_data(buf_data), .mr_req_ready(mr_req_ready), .mr_data_valid(mr_data_valid),
      .mr_data(mr_data), .br_req_ready(br_req_ready), .br_data_valid(br_data_valid),
      .br_data(br_data), .mr_req_valid(mr_req_valid), .mr_addr(mr_addr),
      .rd_beat(rd_beat), .rd_idle(rd_idle)
   );
endmodule

// File: rtl/shb_checker.sv
module shb_checker #(
   parameter int LINE_AW = 26,
   parameter int BEATS   = 4,
   localparam int BEAT_W = $clog2(BEATS)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bw_valid,
   input logic               bw_ready,
   input logic               bw_snoop,
   input logic [LINE_AW-1:0] bw_line,
   input logic               br_req_valid,
   input logic               br_req_ready,
   input logic [LINE_AW-1:0] br_line,
   input logic               br_data_valid,
   input logic               mr_req_valid,
   input logic               mr_req_ready,
   input logic [BEAT_W-1:0]  wr_beat,
   input logic               hold_valid,
   input logic [LINE_AW-1:0] hold_line
);
   a_r3_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (bw_valid && bw_ready && bw_snoop && wr_beat == BEAT_W'(BEATS - 1))
      |=> (hold_valid && hold_line == $past(bw_line)));

   a_r4_hit_data_next: assert property (@(posedge clk) disable iff (!rst_n)
      (br_req_valid && br_req_ready && hold_valid && br_line == hold_line)
      |=> br_data_valid);

   a_r5_miss_requests: assert property (@(posedge clk) disable iff (!rst_n)
      (br_req_valid && br_req_ready && !(hold_valid && br_line == hold_line))
      |=> mr_req_valid);

   a_r5_single_request: assert property (@(posedge clk) disable iff (!rst_n)
      (mr_req_valid && mr_req_ready) |=> !mr_req_valid);

   a_r6_plain_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bw_valid && bw_ready && !bw_snoop && hold_valid && bw_line == hold_line)
      |=> !hold_valid);

   a_r7_write_first: assert property (@(posedge clk) disable iff (!rst_n)
      bw_valid |-> !br_req_ready);
endmodule

bind snoop_hit_buffer shb_checker #(.LINE_AW(LINE_AW), .BEATS(BEATS)) u_chk (
   .clk(clk), .rst_n(rst_n), .bw_valid(bw_valid), .bw_ready(bw_ready),
   .bw_snoop(bw_snoop), .bw_line(bw_line), .br_req_valid(br_req_valid),
   .br_req_ready(br_req_ready), .br_line(br_line), .br_data_valid(br_data_valid),
   .mr_req_valid(mr_req_valid), .mr_req_ready(mr_req_ready), .wr_beat(wr_beat),
   .hold_valid(hold_valid), .hold_line(hold_line)
);

// File: tb/snoop_hit_buffer_bench.sv
`timescale 1ns/1ps
module snoop_hit_buffer_bench;
   localparam int LINE_AW   = 26;
   localparam int DATA_W    = 64;
   localparam int BEATS     = 4;
   localparam int MEM_FIRST = 6;

   typedef struct packed {
      logic [1:0] op;      // 0 read, 1 snoop write-back, 2 plain write
      logic [7:0] line;
      logic       exp_hit;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 8'd5, 1'b0}, '{2'd1, 8'd5, 1'b0}, '{2'd0, 8'd5, 1'b1},
      '{2'd0, 8'd5, 1'b1}, '{2'd0, 8'd6, 1'b0}, '{2'd2, 8'd9, 1'b0},
      '{2'd0, 8'd5, 1'b1}, '{2'd1, 8'd7, 1'b0}, '{2'd0, 8'd5, 1'b0},
      '{2'd0, 8'd7, 1'b1}, '{2'd2, 8'd7, 1'b0}, '{2'd0, 8'd7, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bw_valid = 1'b0, bw_snoop = 1'b0;
   logic [LINE_AW-1:0] bw_line = '0, br_line = '0;
   logic [DATA_W-1:0]  bw_data = '0;
   logic br_req_valid = 1'b0;
   logic bw_ready, br_req_ready, br_data_valid, mw_valid, mr_req_valid;
   logic [DATA_W-1:0] br_data, mw_data, mr_data;
   logic [LINE_AW+1:0] mw_addr;
   logic [LINE_AW-1:0] mr_addr;
   logic mw_ready, mr_req_ready, mr_data_valid;

   logic [DATA_W-1:0] mem [256];
   logic [DATA_W-1:0] ref_mem [256];
   int mcnt = 0;
   logic [LINE_AW-1:0] maddr = '0;
   logic stall_en = 1'b0, stall_tog = 1'b0;
   int checks = 0, fails = 0, stall_seen = 0;

   always #2.5 clk = ~clk;

   snoop_hit_buffer #(.LINE_AW(LINE_AW), .DATA_W(DATA_W), .BEATS(BEATS)) u_snoop_hit_buffer (
      .clk(clk), .rst_n(rst_n), .bw_valid(bw_valid), .bw_ready(bw_ready),
      .bw_snoop(bw_snoop), .bw_line(bw_line), .bw_data(bw_data),
      .br_req_valid(br_req_valid), .br_req_ready(br_req_ready), .br_line(br_line),
      .br_data_valid(br_data_valid), .br_data(br_data), .mw_valid(mw_valid),
      .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
      .mr_req_valid(mr_req_valid), .mr_req_ready(mr_req_ready), .mr_addr(mr_addr),
      .mr_data_valid(mr_data_valid), .mr_data(mr_data)
   );

   // memory model: 6 cycles to first word, then one per cycle
   assign mw_ready      = !(stall_en && stall_tog);
   assign mr_req_ready  = (mcnt == 0);
   assign mr_data_valid = (mcnt >= MEM_FIRST) && (mcnt < MEM_FIRST + BEATS);
   assign mr_data       = mem[{maddr[5:0], 2'(mcnt - MEM_FIRST)}];

   always @(posedge clk) begin
      stall_tog <= ~stall_tog;
      if (mw_valid && mw_ready) mem[mw_addr[7:0]] <= mw_data;
      if (mcnt == 0) begin
         if (mr_req_valid) begin
            mcnt  <= 1;
            maddr <= mr_addr;
         end
      end else begin
         mcnt <= (mcnt == MEM_FIRST + BEATS - 1) ? 0 : mcnt + 1;
      end
   end

   function automatic logic [DATA_W-1:0] pat(input int line, input int seed, input int b);
      return {8'hC3, 8'(seed), 16'(line), 16'(seed * 7 + b), 16'(b)};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_write(input int line, input bit snoop, input int seed);
      for (int b = 0; b < BEATS; b++) begin
         @(negedge clk);
         bw_valid = 1'b1; bw_snoop = snoop; bw_line = LINE_AW'(line);
         bw_data = pat(line, seed, b);
         ref_mem[line * 4 + b] = bw_data;
         #1;
         while (!bw_ready) begin
            if (mw_ready == 1'b0) stall_seen++;
            @(negedge clk); #1;
         end
         @(posedge clk);
      end
      @(negedge clk);
      bw_valid = 1'b0;
   endtask

   task automatic check_mem(input int line, input string req);
      int bad = 0;
      for (int b = 0; b < BEATS; b++) if (mem[line * 4 + b] !== ref_mem[line * 4 + b]) bad++;
      check(bad == 0, req, "memory copy of line mismatched beats", bad, 0);
   endtask

   task automatic do_read(input int line, input bit exp_hit);
      int lat = 0, got = 0, bad = 0, first = -1, last = -1;
      int exp_lat;
      @(negedge clk);
      br_req_valid = 1'b1; br_line = LINE_AW'(line);
      #1;
      while (!br_req_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      while (got < BEATS && lat < 60) begin
         @(negedge clk);
         br_req_valid = 1'b0;
         lat++;
         if (br_data_valid) begin
            if (first < 0) first = lat;
            last = lat;
            if (br_data !== ref_mem[line * 4 + got]) bad++;
            got++;
         end
      end
      exp_lat = exp_hit ? 1 : 1 + MEM_FIRST;
      if (exp_hit)
         check(first == exp_lat && last - first == BEATS - 1, "R4",
               "hit first-beat latency", first, exp_lat);
      else
         check(first == exp_lat && last - first == BEATS - 1, "R5",
               "miss first-beat latency", first, exp_lat);
      check(bad == 0 && got == BEATS, exp_hit ? "R4" : "R5",
            "read data beats wrong", bad, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R7 actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i] = {32'h5A5A_0000, 32'(i)};
         ref_mem[i] = {32'h5A5A_0000, 32'(i)};
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check(!br_data_valid && !mr_req_valid && !mw_valid, "R1",
            "outputs idle after reset", {br_data_valid, mr_req_valid, mw_valid}, 0);
      check(br_req_ready == 1'b1, "R1", "read ready after reset", br_req_ready, 1);

      // table walk: R3 capture, R4 hit, R5 miss, R6 invalidate, R8 repeated hit
      for (int i = 0; i < NV; i++) begin
         case (VECS[i].op)
            2'd0: do_read(int'(VECS[i].line), VECS[i].exp_hit);
            2'd1: begin
               do_write(int'(VECS[i].line), 1'b1, i);
               check_mem(int'(VECS[i].line), "R2");
            end
            default: begin
               do_write(int'(VECS[i].line), 1'b0, i);
               check_mem(int'(VECS[i].line), "R2");
            end
         endcase
      end

      // R7: write and read offered in the same cycle; write first, read then misses (R6)
      do_write(11, 1'b1, 40);
      fork
         do_write(11, 1'b0, 41);
         do_read(11, 1'b0);
         begin
            @(negedge clk); #1.5;
            check(br_req_ready == 1'b0 && bw_valid == 1'b1, "R7",
                  "read accepted while write offered", br_req_ready, 0);
         end
      join

      // R2: memory back-pressure on a snoop write-back, then R3/R4 hit
      stall_en = 1'b1;
      do_write(20, 1'b1, 50);
      stall_en = 1'b0;
      check(stall_seen > 0, "R2", "no stall observed on bw_ready", stall_seen, 1);
      check_mem(20, "R2");
      do_read(20, 1'b1);

      // R3: new write-back discards previous copy
      do_write(21, 1'b1, 51);
      do_read(20, 1'b0);
      do_read(21, 1'b1);

      // R1: reset clears a recorded copy
      do_write(3, 1'b1, 60);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      do_read(3, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule